// File: doc/BRIEF.md
# Transmit Frame Timing Generator

This block produces the nested transmit timing counters of a radio fronthaul link from a free-running link clock. Each clock carries one 32-bit word. The block counts the word inside a basic frame, the basic frame inside a hyperframe, the hyperframe inside a 10 ms radio frame, and the radio frame number. It flags the first word of every hyperframe and of every radio frame, so that downstream framing and auxiliary data logic can align to those boundaries.

A start offset input, counted in basic frames from the radio frame boundary, selects one basic frame. A start flag is held through that whole basic frame, once after reset and once after each resynchronisation. A rising edge on the resync input restarts the radio frame after a fixed latency. The lower counters clear and the radio frame number steps forward by one. The counters keep running during that latency.

Defaults: 16 words per basic frame, 256 basic frames per hyperframe, 150 hyperframes per radio frame, a 12-bit radio frame number and a resync latency of 7 clocks. All of these are parameters. The word count and the frame counts must be at least 2.

Top module: `frame_timing_gen`

## Requirements
- R1: `word_idx` steps by one on each clock from 0 to WORDS_PER_BF-1, then returns to 0. The return to 0 advances `bf_idx`.
- R2: `bf_idx` runs from 0 to BF_PER_HF-1 and holds between word wraps. When it wraps from its top value it returns to 0 and advances `hf_num`.
- R3: `hf_num` runs from 0 to HF_PER_RF-1. When it wraps from its top value it returns to 0 and advances `rf_num`.
- R4: `rf_num` is RFN_W bits wide and wraps from 2^RFN_W-1 to 0.
- R5: `hf_pulse` is 1 exactly when `word_idx` = 0 and `bf_idx` = 0.
- R6: `rf_pulse` is 1 exactly when `word_idx` = 0, `bf_idx` = 0 and `hf_num` = 0.
- R7: The position of a basic frame in the radio frame is `hf_num`*BF_PER_HF + `bf_idx`. `start_flag` is 1 for every word of the first basic frame whose position equals `start_offset`, and it does this only once. An offset of BF_PER_HF*HF_PER_RF or more never raises it.
- R8: Let a rising edge of `resync` be sampled at clock edge N, meaning it is 1 there and was 0 at edge N-1. Right after edge N+RESYNC_LAT (N+7 by default), `word_idx`, `bf_idx` and `hf_num` are 0 and both pulses are 1. At the same point `rf_num` equals its value before that edge plus one. Until then the counters keep running normally.
- R9: Holding `resync` at 1 causes no further restart. A new rising edge during the latency window starts the window again from that new edge.
- R10: A resync restart re-arms `start_flag`, so it fires again for the basic frame at `start_offset` in the restarted timing.
- R11: After reset, all counters are 0 and both pulses are 1. `start_flag` is 1 only if `start_offset` is 0. A `resync` that is already 1 as reset ends does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock, one word per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_offset | input | $clog2(BF_PER_HF*HF_PER_RF)+1 | Basic frame position that receives the start flag |
| resync | input | 1 | Radio frame restart request, acts on the rising edge |
| word_idx | output | $clog2(WORDS_PER_BF) | Word index inside the basic frame |
| bf_idx | output | $clog2(BF_PER_HF) | Basic frame index X inside the hyperframe |
| hf_num | output | $clog2(HF_PER_RF) | Hyperframe number inside the radio frame |
| rf_num | output | RFN_W | Radio frame number |
| hf_pulse | output | 1 | First word of a hyperframe |
| rf_pulse | output | 1 | First word of a radio frame |
| start_flag | output | 1 | Held through the selected basic frame |

## Verification
All counters and pulses reflect the clock edge just past, so the bench drives inputs at a falling edge. After each rising edge it updates its arithmetic model of elapsed cycles and compares every output at the next falling edge. A resync restart is due RESYNC_LAT rising edges after the edge that first samples the input high. The model counts exactly those edges before it rebases its cycle count and its radio frame number. The restart cycle is therefore checked in that one cycle and in no other.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
    localparam int DEF_WORDS_PER_BF = 16;
    localparam int DEF_BF_PER_HF    = 256;
    localparam int DEF_HF_PER_RF    = 150;
    localparam int DEF_RFN_W        = 12;
    localparam int DEF_RESYNC_LAT   = 7;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_WAIT = 1'b1
    } rs_phase_e;
endpackage

// File: rtl/ftg_resync_delay.sv
module ftg_resync_delay
    import ftg_pkg::*;
#(
    parameter int LAT = DEF_RESYNC_LAT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic resync_i,
    output logic restart_o
);
    localparam int CNT_W = (LAT > 2) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic             prev;
        rs_phase_e        phase;
        logic [CNT_W-1:0] cnt;
    } rs_state_t;

    localparam rs_state_t RST_VAL = '{prev: 1'b1, phase: RS_IDLE, cnt: '0};

    rs_state_t st_d, st_q;
    logic      rise;
    logic      go;

    always_comb begin
        st_d      = st_q;
        rise      = resync_i & ~st_q.prev;
        go        = (st_q.phase == RS_WAIT) && (st_q.cnt == '0);
        st_d.prev = resync_i;
        if (rise) begin
            st_d.phase = RS_WAIT;
            st_d.cnt   = CNT_W'(LAT - 1);
        end else if (go) begin
            st_d.phase = RS_IDLE;
        end else if (st_q.phase == RS_WAIT) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign restart_o = go;

    // R8: a sampled rising edge opens a full latency window
    a_r8_window_open: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_i && !st_q.prev) |=> (st_q.phase == RS_WAIT && st_q.cnt == CNT_W'(LAT - 1)));

    // R8: the window counts down one per clock
    a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == RS_WAIT && st_q.cnt != '0 && !(resync_i && !st_q.prev))
        |=> (st_q.phase == RS_WAIT && st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R9: a held level does not open a window
    a_r9_level_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (resync_i && st_q.prev && st_q.phase == RS_IDLE) |=> (st_q.phase == RS_IDLE));
endmodule

// File: rtl/ftg_counter_chain.sv
module ftg_counter_chain
    import ftg_pkg::*;
#(
    parameter int WORDS_PER_BF = DEF_WORDS_PER_BF,
    parameter int BF_PER_HF    = DEF_BF_PER_HF,
    parameter int HF_PER_RF    = DEF_HF_PER_RF,
    parameter int RFN_W        = DEF_RFN_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          restart_i,
    output logic [$clog2(WORDS_PER_BF)-1:0] word_o,
    output logic [$clog2(BF_PER_HF)-1:0]    x_o,
    output logic [$clog2(HF_PER_RF)-1:0]    hfn_o,
    output logic [RFN_W-1:0]                rfn_o,
    output logic                          bf_end_o,
    output logic                          hf_pulse_o,
    output logic                          rf_pulse_o
);
    localparam int WD_W = $clog2(WORDS_PER_BF);
    localparam int X_W  = $clog2(BF_PER_HF);
    localparam int HF_W = $clog2(HF_PER_RF);

    typedef struct packed {
        logic [WD_W-1:0]  word;
        logic [X_W-1:0]   x;
        logic [HF_W-1:0]  hfn;
        logic [RFN_W-1:0] rfn;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       word_last, x_last, hf_last;

    always_comb begin
        st_d      = st_q;
        word_last = (st_q.word == WD_W'(WORDS_PER_BF - 1));
        x_last    = (st_q.x == X_W'(BF_PER_HF - 1));
        hf_last   = (st_q.hfn == HF_W'(HF_PER_RF - 1));
        if (restart_i) begin
            st_d.word = '0;
            st_d.x    = '0;
            st_d.hfn  = '0;
            st_d.rfn  = st_q.rfn + 1'b1;
        end else if (word_last) begin
            st_d.word = '0;
            if (x_last) begin
                st_d.x = '0;
                if (hf_last) begin
                    st_d.hfn = '0;
                    st_d.rfn = st_q.rfn + 1'b1;
                end else begin
                    st_d.hfn = st_q.hfn + 1'b1;
                end
            end else begin
                st_d.x = st_q.x + 1'b1;
            end
        end else begin
            st_d.word = st_q.word + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o     = st_q.word;
    assign x_o        = st_q.x;
    assign hfn_o      = st_q.hfn;
    assign rfn_o      = st_q.rfn;
    assign bf_end_o   = word_last;
    assign hf_pulse_o = (st_q.word == '0) && (st_q.x == '0);
    assign rf_pulse_o = hf_pulse_o && (st_q.hfn == '0);

    // R1: the word index wraps to zero after its top value
    a_r1_word_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o == WD_W'(WORDS_PER_BF - 1)) |=> (word_o == '0));

    // R2: X holds between word wraps when no restart is due
    a_r2_x_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bf_end_o && !restart_i) |=> $stable(x_o));

    // R3: the hyperframe number stays inside its range
    a_r3_hfn_range: assert property (@(posedge clk) disable iff (!rst_n)
        (hfn_o <= HF_W'(HF_PER_RF - 1)));

    // R8: a restart clears the lower counters and steps the radio frame number
    a_r8_restart_state: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (word_o == '0 && x_o == '0 && hfn_o == '0 && rf_pulse_o
                       && rfn_o == $past(rfn_o) + RFN_W'(1)));
endmodule

// File: rtl/ftg_start_gate.sv
module ftg_start_gate
    import ftg_pkg::*;
#(
    parameter int BF_PER_HF = DEF_BF_PER_HF,
    parameter int HF_PER_RF = DEF_HF_PER_RF
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         restart_i,
    input  logic                                         bf_end_i,
    input  logic [$clog2(BF_PER_HF)-1:0]                 x_i,
    input  logic [$clog2(HF_PER_RF)-1:0]                 hfn_i,
    input  logic [$clog2(BF_PER_HF*HF_PER_RF):0]         offset_i,
    output logic                                         start_o
);
    localparam int OFF_W = $clog2(BF_PER_HF * HF_PER_RF) + 1;

    typedef struct packed {
        logic armed;
    } gate_state_t;

    gate_state_t      st_d, st_q;
    logic [OFF_W-1:0] pos;
    logic             match;

    always_comb begin
        st_d  = st_q;
        pos   = OFF_W'(hfn_i) * OFF_W'(BF_PER_HF) + OFF_W'(x_i);
        match = (pos == offset_i);
        if (restart_i) begin
            st_d.armed = 1'b1;
        end else if (st_q.armed && match && bf_end_i) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{armed: 1'b1};
        else        st_q <= st_d;
    end

    assign start_o = st_q.armed && match;

    // R7: the flag stays up through the rest of its basic frame
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !bf_end_i && !restart_i) |=> (start_o || offset_i != $past(offset_i)));

    // R7: once spent, the flag stays spent until a restart
    a_r7_once: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !restart_i) |=> !start_o);

    // R10: a restart re-arms the flag
    a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> st_q.armed);
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
    import ftg_pkg::*;
#(
    parameter int WORDS_PER_BF = DEF_WORDS_PER_BF,
    parameter int BF_PER_HF    = DEF_BF_PER_HF,
    parameter int HF_PER_RF    = DEF_HF_PER_RF,
    parameter int RFN_W        = DEF_RFN_W,
    parameter int RESYNC_LAT   = DEF_RESYNC_LAT
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [$clog2(BF_PER_HF*HF_PER_RF):0]      start_offset,
    input  logic                                      resync,
    output logic [$clog2(WORDS_PER_BF)-1:0]           word_idx,
    output logic [$clog2(BF_PER_HF)-1:0]              bf_idx,
    output logic [$clog2(HF_PER_RF)-1:0]              hf_num,
    output logic [RFN_W-1:0]                          rf_num,
    output logic                                      hf_pulse,
    output logic                                      rf_pulse,
    output logic                                      start_flag
);
    logic restart;
    logic bf_end;

    ftg_resync_delay #(
        .LAT (RESYNC_LAT)
    ) u_resync (
        .clk       (clk),
        .rst_n     (rst_n),
        .resync_i  (resync),
        .restart_o (restart)
    );

    ftg_counter_chain #(
        .WORDS_PER_BF (WORDS_PER_BF),
        .BF_PER_HF    (BF_PER_HF),
        .HF_PER_RF    (HF_PER_RF),
        .RFN_W        (RFN_W)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .word_o     (word_idx),
        .x_o        (bf_idx),
        .hfn_o      (hf_num),
        .rfn_o      (rf_num),
        .bf_end_o   (bf_end),
        .hf_pulse_o (hf_pulse),
        .rf_pulse_o (rf_pulse)
    );

    ftg_start_gate #(
        .BF_PER_HF (BF_PER_HF),
        .HF_PER_RF (HF_PER_RF)
    ) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .bf_end_i  (bf_end),
        .x_i       (bf_idx),
        .hfn_i     (hf_num),
        .offset_i  (start_offset),
        .start_o   (start_flag)
    );

    // R6: a radio frame start is always also a hyperframe start
    a_r6_rf_within_hf: assert property (@(posedge clk) disable iff (!rst_n)
        rf_pulse |-> hf_pulse);
endmodule

// File: tb/test_frame_timing_gen.sv
module test_frame_timing_gen;
    localparam int W    = 4;
    localparam int B    = 8;
    localparam int H    = 5;
    localparam int RW   = 3;
    localparam int LAT  = 7;
    localparam int OW   = $clog2(B * H) + 1;
    localparam int RMOD = 1 << RW;

    // stimulus table: start offset, resync pulse length, cycles to run
    localparam int SEG_N = 8;
    localparam int SEG_OFF[SEG_N]   = '{0, 13, 13, 39, 40, 5, 2, 21};
    localparam int SEG_PULSE[SEG_N] = '{0, 0, 2, 0, 0, 1, 0, 3};
    localparam int SEG_LEN[SEG_N]   = '{400, 200, 300, 200, 200, 50, 1400, 250};

    logic          clk = 1'b0;
    logic          rst_n;
    logic [OW-1:0] start_offset;
    logic          resync;
    logic [$clog2(W)-1:0] word_idx;
    logic [$clog2(B)-1:0] bf_idx;
    logic [$clog2(H)-1:0] hf_num;
    logic [RW-1:0]        rf_num;
    logic          hf_pulse, rf_pulse, start_flag;

    always #5 clk = ~clk;

    frame_timing_gen #(
        .WORDS_PER_BF (W),
        .BF_PER_HF    (B),
        .HF_PER_RF    (H),
        .RFN_W        (RW),
        .RESYNC_LAT   (LAT)
    ) i_frame_timing_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_offset (start_offset),
        .resync       (resync),
        .word_idx     (word_idx),
        .bf_idx       (bf_idx),
        .hf_num       (hf_num),
        .rf_num       (rf_num),
        .hf_pulse     (hf_pulse),
        .rf_pulse     (rf_pulse),
        .start_flag   (start_flag)
    );

    int    n_total = 0;
    int    n_bad   = 0;
    bit    done    = 0;
    string ovr     = "";

    // reference model state
    int t, base_t, base_rfn, since;
    bit armed, rs_prev, pend, just, ever;

    function automatic int m_total();  return t - base_t; endfunction
    function automatic int m_word();   return m_total() % W; endfunction
    function automatic int m_x();      return (m_total() / W) % B; endfunction
    function automatic int m_hfn();    return (m_total() / (W * B)) % H; endfunction
    function automatic int m_rfn();    return (base_rfn + m_total() / (W * B * H)) % RMOD; endfunction
    function automatic int m_pos();    return (m_total() / W) % (B * H); endfunction
    function automatic bit m_start();  return armed && (m_pos() == int'(start_offset)); endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0d", tag, act, exp, t);
        end
    endtask

    function automatic string pick(input string dflt);
        return (ovr != "") ? ovr : dflt;
    endfunction

    task automatic check_all();
        int e;
        e = m_word();
        chk(int'(word_idx) == e, just ? "R8 word" : pick("R1 word"), int'(word_idx), e);
        e = m_x();
        chk(int'(bf_idx) == e, just ? "R8 x" : pick("R2 x"), int'(bf_idx), e);
        e = m_hfn();
        chk(int'(hf_num) == e, just ? "R8 hfn" : pick("R3 hfn"), int'(hf_num), e);
        e = m_rfn();
        chk(int'(rf_num) == e, just ? "R8 rfn" : pick("R4 rfn"), int'(rf_num), e);
        e = (m_word() == 0 && m_x() == 0) ? 1 : 0;
        chk(int'(hf_pulse) == e, pick("R5 hf_pulse"), int'(hf_pulse), e);
        e = (m_word() == 0 && m_x() == 0 && m_hfn() == 0) ? 1 : 0;
        chk(int'(rf_pulse) == e, pick("R6 rf_pulse"), int'(rf_pulse), e);
        e = int'(m_start());
        chk(int'(start_flag) == e, ever ? "R10 start" : pick("R7 start"), int'(start_flag), e);
    endtask

    task automatic step();
        int  pw, prfn;
        bit  pst, rise;
        pw   = m_word();
        prfn = m_rfn();
        pst  = m_start();
        if (pst && pw == W - 1) armed = 0;
        @(posedge clk);
        t++;
        rise    = resync && !rs_prev;
        rs_prev = resync;
        just    = 0;
        if (pend) begin
            since++;
            if (since == LAT) begin
                pend     = 0;
                just     = 1;
                base_t   = t;
                base_rfn = (prfn + 1) % RMOD;
                armed    = 1;
                ever     = 1;
            end
        end
        if (rise) begin
            pend  = 1;
            since = 0;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset(input int off);
        rst_n        = 1'b0;
        resync       = 1'b0;
        start_offset = OW'(off);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n    = 1'b1;
        t        = 0;
        base_t   = 0;
        base_rfn = 0;
        since    = 0;
        armed    = 1;
        rs_prev  = 1;
        pend     = 0;
        just     = 0;
        ever     = 0;
        #1;
        // R11: reset state
        chk(word_idx == '0 && bf_idx == '0 && hf_num == '0, "R11 counters", int'(word_idx) + int'(bf_idx) + int'(hf_num), 0);
        chk(rf_num == '0, "R11 rfn", int'(rf_num), 0);
        chk(hf_pulse && rf_pulse, "R11 pulses", int'(hf_pulse) + int'(rf_pulse), 2);
        chk(int'(start_flag) == int'(off == 0), "R11 start", int'(start_flag), int'(off == 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset(0);

        // table walk: R1..R8, R10 under several offsets and pulses
        for (int i = 0; i < SEG_N; i++) begin
            start_offset = OW'(SEG_OFF[i]);
            if (SEG_PULSE[i] > 0) begin
                resync = 1'b1;
                for (int k = 0; k < SEG_PULSE[i]; k++) step();
                resync = 1'b0;
            end
            for (int k = 0; k < SEG_LEN[i]; k++) step();
        end

        // R9: second rising edge inside the latency window restarts it
        ovr    = "R9 retrigger";
        resync = 1'b1;
        step();
        resync = 1'b0;
        repeat (3) step();
        resync = 1'b1;
        step();
        resync = 1'b0;
        repeat (40) step();

        // R9: a level held high restarts only once
        ovr    = "R9 level";
        resync = 1'b1;
        repeat (200) step();
        resync = 1'b0;
        repeat (20) step();
        ovr = "";

        // R11: reset with a high resync level and nonzero offset
        do_reset(3);
        resync = 1'b1;
        rs_prev = 1'b1;
        repeat (30) step();
        resync = 1'b0;
        repeat (30) step();

        // R7: offset beyond the radio frame never raises the flag
        do_reset(B * H + 5);
        repeat (3 * W * B * H) step();

        done = 1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule